// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host with a 32-bit memory-mapped register file reach a slow, byte-addressed subsystem bus one access at a time. The host never touches the subsystem bus itself. It writes a control word carrying the subsystem address, a direction flag, a size flag and two groups of byte enables. A write is started by the host writing the lower data register after the control word. A read is started by the control-word write itself. While the transfer is pending a busy bit in the control word stays high; the host polls it, and once it drops read results sit in the data registers.

On the subsystem side the bridge holds a request, with address, direction, byte enables and write data, steady until the subsystem acknowledges. The subsystem then supplies read data on the same cycle. The bridge also merges two interrupt causes, a completed transfer and a rising edge on the subsystem's interrupt line, into a flag register with write-one-to-clear bits. An enable register gates each flag onto a single host interrupt output. The subsystem interrupt line first passes through a synchroniser whose depth is a parameter.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the ID register (offset 0x00) reads the ID_VALUE parameter, the control (0x04), lower data (0x08), upper data (0x0C), interrupt enable (0x10) and interrupt flag (0x14) registers read zero, and sub_req and irq_out are low.
- R2: A control write while idle stores the subsystem address in bits SUB_AW-1:0, the lower-word byte enables in bits 19:16, the upper-word byte enables in bits 23:20, the direction in bit 24 (1 = read) and the size in bit 25 (1 = both data words). These read back in place, with busy in bit 31 and all other bits zero; a control write with bit 24 at 0 starts no transfer.
- R3: Writing the lower data register while idle, with the stored direction at 0, raises busy and sub_req in the following cycle with sub_we high, sub_addr from the control word, sub_wdata equal to {upper data, written lower data}, and sub_be equal to {size ? upper enables : 0000, lower enables}.
- R4: Writing the control word with bit 24 at 1 while idle raises busy and sub_req in the following cycle with sub_we low and address and byte enables taken from that written word.
- R5: sub_req and all request fields stay stable until sub_ack is sampled high with sub_req; in the next cycle sub_req and busy are low.
- R6: On the acknowledge of a read, the lower data register takes sub_rdata[31:0]; the upper data register takes sub_rdata[63:32] only when the size bit is 1 and otherwise keeps its value.
- R7: While busy, host writes to the control, lower data and upper data registers are ignored: no register changes and no second transfer starts.
- R8: Flag bit 0 is set when any transfer completes; flag bit 1 is set on a rising edge of sub_irq, and a sub_irq level held high does not set it again after it is cleared.
- R9: Writing 1 to a flag bit clears it, writing 0 leaves it; a set occurring in the same cycle as a clear wins.
- R10: The enable register holds bits 1:0 and reads them back; irq_out is high exactly when some flag bit is set with its enable bit set.
- R11: Reads of unmapped offsets return zero, and writes to the ID register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | Host write when high |
| host_addr | input | HOST_AW | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| sub_req | output | 1 | Subsystem request, held until acknowledged |
| sub_we | output | 1 | Subsystem write when high, read when low |
| sub_addr | output | SUB_AW | Subsystem byte address |
| sub_be | output | 8 | Subsystem byte enables, lane 0 lowest |
| sub_wdata | output | 64 | Subsystem write data |
| sub_ack | input | 1 | Subsystem acknowledge |
| sub_rdata | input | 64 | Subsystem read data, valid with sub_ack |
| sub_irq | input | 1 | Subsystem interrupt level |
| irq_out | output | 1 | Host interrupt |

## Verification
Write transfers are driven with random addresses, byte enables, size and data words, which separates a correct byte-lane mask and data ordering from swapped or unmasked lanes. Read transfers alternate the size bit against a subsystem model whose data depends on the address, so an upper register that is loaded when it should be kept, or a lower register that is not loaded, shows at once. Acknowledge delays vary from zero to many cycles; some transfers get a long delay during which the host rewrites every launch register, which tells real busy gating apart from a bridge that restarts or corrupts. The interrupt pattern walks enable and flag combinations, and clears while sub_irq is still high to separate edge from level detection.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

   localparam int HDW = 32;

   localparam logic [7:0] OFF_ID   = 8'h00;
   localparam logic [7:0] OFF_CTRL = 8'h04;
   localparam logic [7:0] OFF_DLO  = 8'h08;
   localparam logic [7:0] OFF_DHI  = 8'h0C;
   localparam logic [7:0] OFF_IEN  = 8'h10;
   localparam logic [7:0] OFF_IFLG = 8'h14;

   localparam int CB_BUSY   = 31;
   localparam int CB_SIZE   = 25;
   localparam int CB_DIR    = 24;
   localparam int CB_BEU_LO = 20;
   localparam int CB_BEL_LO = 16;

   localparam int NSRC    = 2;
   localparam int SRC_IF  = 0;
   localparam int SRC_SUB = 1;

   typedef enum logic {XS_IDLE, XS_WAIT} xfer_st_t;

   typedef struct packed {
      logic       size;
      logic       dir;
      logic [3:0] be_u;
      logic [3:0] be_l;
   } ctl_t;

endpackage

// File: rtl/ibr_regs.sv
module ibr_regs
   import ibr_pkg::*;
#(
   parameter int HOST_AW = 8,
   parameter int SUB_AW  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_sel,
   input  logic                host_we,
   input  logic [HOST_AW-1:0]  host_addr,
   input  logic [HDW-1:0]      host_wdata,
   input  logic                busy,
   input  logic                rd_done,
   input  logic [2*HDW-1:0]    rd_word,
   output ctl_t                ctl_q,
   output logic [SUB_AW-1:0]   addr_q,
   output logic [HDW-1:0]      dlo_q,
   output logic [HDW-1:0]      dhi_q,
   output logic                launch_wr,
   output logic                launch_rd,
   output logic [SUB_AW-1:0]   lx_addr,
   output logic [7:0]          lx_be,
   output logic [2*HDW-1:0]    lx_wdata,
   output logic                ien_we,
   output logic [NSRC-1:0]     iflg_clr
);

   logic host_wr;
   logic hit_ctrl, hit_dlo, hit_dhi, hit_ien, hit_iflg;
   logic ctrl_we, dlo_we, dhi_we;
   ctl_t ctl_new;

   assign host_wr  = host_sel && host_we;
   assign hit_ctrl = (host_addr == HOST_AW'(OFF_CTRL));
   assign hit_dlo  = (host_addr == HOST_AW'(OFF_DLO));
   assign hit_dhi  = (host_addr == HOST_AW'(OFF_DHI));
   assign hit_ien  = (host_addr == HOST_AW'(OFF_IEN));
   assign hit_iflg = (host_addr == HOST_AW'(OFF_IFLG));

   // launch registers are frozen while a transfer is pending
   assign ctrl_we = host_wr && hit_ctrl && !busy;
   assign dlo_we  = host_wr && hit_dlo  && !busy;
   assign dhi_we  = host_wr && hit_dhi  && !busy;

   assign ctl_new.size = host_wdata[CB_SIZE];
   assign ctl_new.dir  = host_wdata[CB_DIR];
   assign ctl_new.be_u = host_wdata[CB_BEU_LO +: 4];
   assign ctl_new.be_l = host_wdata[CB_BEL_LO +: 4];

   assign launch_rd = ctrl_we && ctl_new.dir;
   assign launch_wr = dlo_we && !ctl_q.dir;

   assign ien_we   = host_wr && hit_ien;
   assign iflg_clr = (host_wr && hit_iflg) ? host_wdata[NSRC-1:0] : '0;

   // a read launch takes its fields from the word being written
   always_comb begin
      if (launch_rd) begin
         lx_addr = host_wdata[SUB_AW-1:0];
         lx_be   = {ctl_new.size ? ctl_new.be_u : 4'b0000, ctl_new.be_l};
      end else begin
         lx_addr = addr_q;
         lx_be   = {ctl_q.size ? ctl_q.be_u : 4'b0000, ctl_q.be_l};
      end
      lx_wdata = {dhi_q, host_wdata};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         addr_q <= '0;
      end else if (ctrl_we) begin
         ctl_q  <= ctl_new;
         addr_q <= host_wdata[SUB_AW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dlo_q <= '0;
      end else if (dlo_we) begin
         dlo_q <= host_wdata;
      end else if (rd_done) begin
         dlo_q <= rd_word[HDW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dhi_q <= '0;
      end else if (dhi_we) begin
         dhi_q <= host_wdata;
      end else if (rd_done && ctl_q.size) begin
         dhi_q <= rd_word[2*HDW-1:HDW];
      end
   end

   AST_BUSY_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && host_wr && hit_ctrl |=> $stable(ctl_q) && $stable(addr_q)); // R7

   AST_BUSY_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !rd_done && host_wr && (hit_dlo || hit_dhi) |=> $stable(dlo_q) && $stable(dhi_q)); // R7

endmodule

// File: rtl/ibr_xfer.sv
module ibr_xfer
   import ibr_pkg::*;
#(
   parameter int SUB_AW = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                launch_wr,
   input  logic                launch_rd,
   input  logic [SUB_AW-1:0]   lx_addr,
   input  logic [7:0]          lx_be,
   input  logic [2*HDW-1:0]    lx_wdata,
   input  logic                sub_ack,
   output logic                busy,
   output logic                sub_req,
   output logic                sub_we,
   output logic [SUB_AW-1:0]   sub_addr,
   output logic [7:0]          sub_be,
   output logic [2*HDW-1:0]    sub_wdata,
   output logic                xfer_done,
   output logic                rd_done
);

   xfer_st_t st_q;
   logic     start;

   assign start     = (st_q == XS_IDLE) && (launch_wr || launch_rd);
   assign busy      = (st_q == XS_WAIT);
   assign sub_req   = busy;
   assign xfer_done = busy && sub_ack;
   assign rd_done   = xfer_done && !sub_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= XS_IDLE;
      end else begin
         unique case (st_q)
            XS_IDLE: if (start)   st_q <= XS_WAIT;
            XS_WAIT: if (sub_ack) st_q <= XS_IDLE;
            default:              st_q <= XS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sub_we    <= 1'b0;
         sub_addr  <= '0;
         sub_be    <= '0;
         sub_wdata <= '0;
      end else if (start) begin
         sub_we    <= launch_wr;
         sub_addr  <= lx_addr;
         sub_be    <= lx_be;
         sub_wdata <= launch_wr ? lx_wdata : '0;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sub_req && !sub_ack |=> sub_req && $stable(sub_addr) && $stable(sub_we) && $stable(sub_be) && $stable(sub_wdata)); // R5

   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      sub_req && sub_ack |=> !sub_req && !busy); // R5

   AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_wr || launch_rd) |-> !busy); // R7

endmodule

// File: rtl/ibr_irq.sv
module ibr_irq
   import ibr_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_irq,
   input  logic              xfer_done,
   input  logic              ien_we,
   input  logic [NSRC-1:0]   ien_wdata,
   input  logic [NSRC-1:0]   iflg_clr,
   output logic [NSRC-1:0]   ien_q,
   output logic [NSRC-1:0]   iflg_q,
   output logic              irq_out
);

   logic            sub_s;
   logic            sub_prev;
   logic [NSRC-1:0] iflg_set;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sub_s = sub_irq;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], sub_irq} & {SYNC_STAGES{1'b1}};
         end
         assign sub_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sub_prev <= 1'b0;
      else        sub_prev <= sub_s;
   end

   always_comb begin
      iflg_set          = '0;
      iflg_set[SRC_IF]  = xfer_done;
      iflg_set[SRC_SUB] = sub_s && !sub_prev;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) iflg_q <= '0;
      else        iflg_q <= (iflg_q & ~iflg_clr) | iflg_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ien_q <= '0;
      else if (ien_we) ien_q <= ien_wdata;
   end

   assign irq_out = |(iflg_q & ien_q);

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|iflg_set) |=> ((iflg_q & $past(iflg_set)) == $past(iflg_set))); // R9

   AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (|(iflg_clr & ~iflg_set)) |=> ((iflg_q & $past(iflg_clr & ~iflg_set)) == '0)); // R9

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq_out); // R10

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
   import ibr_pkg::*;
#(
   parameter int          HOST_AW     = 8,
   parameter int          SUB_AW      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] ID_VALUE    = 32'h1B00_5EED
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_sel,
   input  logic                host_we,
   input  logic [HOST_AW-1:0]  host_addr,
   input  logic [31:0]         host_wdata,
   output logic [31:0]         host_rdata,
   output logic                sub_req,
   output logic                sub_we,
   output logic [SUB_AW-1:0]   sub_addr,
   output logic [7:0]          sub_be,
   output logic [63:0]         sub_wdata,
   input  logic                sub_ack,
   input  logic [63:0]         sub_rdata,
   input  logic                sub_irq,
   output logic                irq_out
);

   localparam int ADDR_PAD = 16 - SUB_AW;

   generate
      if (SUB_AW < 1 || SUB_AW > 16) begin : g_bad_sub_aw
         $error("SUB_AW must lie in 1..16 to fit the control word");
      end
      if (HOST_AW < 5) begin : g_bad_host_aw
         $error("HOST_AW must be at least 5 to reach every register");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   ctl_t               ctl_q;
   logic [SUB_AW-1:0]  addr_q;
   logic [HDW-1:0]     dlo_q, dhi_q;
   logic               launch_wr, launch_rd;
   logic [SUB_AW-1:0]  lx_addr;
   logic [7:0]         lx_be;
   logic [2*HDW-1:0]   lx_wdata;
   logic               ien_we;
   logic [NSRC-1:0]    iflg_clr;
   logic [NSRC-1:0]    ien_q, iflg_q;
   logic               busy, xfer_done, rd_done;
   logic [15:0]        addr_field;

   ibr_regs #(.HOST_AW(HOST_AW), .SUB_AW(SUB_AW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_sel   (host_sel),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .busy       (busy),
      .rd_done    (rd_done),
      .rd_word    (sub_rdata),
      .ctl_q      (ctl_q),
      .addr_q     (addr_q),
      .dlo_q      (dlo_q),
      .dhi_q      (dhi_q),
      .launch_wr  (launch_wr),
      .launch_rd  (launch_rd),
      .lx_addr    (lx_addr),
      .lx_be      (lx_be),
      .lx_wdata   (lx_wdata),
      .ien_we     (ien_we),
      .iflg_clr   (iflg_clr)
   );

   ibr_xfer #(.SUB_AW(SUB_AW)) u_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_wr  (launch_wr),
      .launch_rd  (launch_rd),
      .lx_addr    (lx_addr),
      .lx_be      (lx_be),
      .lx_wdata   (lx_wdata),
      .sub_ack    (sub_ack),
      .busy       (busy),
      .sub_req    (sub_req),
      .sub_we     (sub_we),
      .sub_addr   (sub_addr),
      .sub_be     (sub_be),
      .sub_wdata  (sub_wdata),
      .xfer_done  (xfer_done),
      .rd_done    (rd_done)
   );

   ibr_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sub_irq    (sub_irq),
      .xfer_done  (xfer_done),
      .ien_we     (ien_we),
      .ien_wdata  (host_wdata[NSRC-1:0]),
      .iflg_clr   (iflg_clr),
      .ien_q      (ien_q),
      .iflg_q     (iflg_q),
      .irq_out    (irq_out)
   );

   generate
      if (ADDR_PAD > 0) begin : g_addr_pad
         assign addr_field = {{ADDR_PAD{1'b0}}, addr_q};
      end else begin : g_addr_full
         assign addr_field = addr_q;
      end
   endgenerate

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         HOST_AW'(OFF_ID):   host_rdata = ID_VALUE;
         HOST_AW'(OFF_CTRL): begin
            host_rdata[CB_BUSY]         = busy;
            host_rdata[CB_SIZE]         = ctl_q.size;
            host_rdata[CB_DIR]          = ctl_q.dir;
            host_rdata[CB_BEU_LO +: 4]  = ctl_q.be_u;
            host_rdata[CB_BEL_LO +: 4]  = ctl_q.be_l;
            host_rdata[15:0]            = addr_field;
         end
         HOST_AW'(OFF_DLO):  host_rdata = dlo_q;
         HOST_AW'(OFF_DHI):  host_rdata = dhi_q;
         HOST_AW'(OFF_IEN):  host_rdata[NSRC-1:0] = ien_q;
         HOST_AW'(OFF_IFLG): host_rdata[NSRC-1:0] = iflg_q;
         default:            host_rdata = '0;
      endcase
   end

   AST_WR_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      host_sel && host_we && host_addr == HOST_AW'(OFF_DLO) && !sub_req && !ctl_q.dir
      |=> sub_req && sub_we && sub_wdata[31:0] == $past(host_wdata)); // R3

   AST_RD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      host_sel && host_we && host_addr == HOST_AW'(OFF_CTRL) && !sub_req && host_wdata[CB_DIR]
      |=> sub_req && !sub_we); // R4

   AST_NO_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
      !sub_req && !(host_sel && host_we) |=> !sub_req); // R2

endmodule

// File: tb/tb_ind_reg_bridge.sv
`timescale 1ns/1ps
module tb_ind_reg_bridge;

   localparam logic [31:0] IDV = 32'h1B00_5EED;
   localparam logic [7:0] A_ID = 8'h00, A_CTRL = 8'h04, A_DLO = 8'h08,
                          A_DHI = 8'h0C, A_IEN = 8'h10, A_IFLG = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        host_sel, host_we;
   logic [7:0]  host_addr;
   logic [31:0] host_wdata, host_rdata;
   logic        sub_req, sub_we, sub_ack, sub_irq, irq_out;
   logic [7:0]  sub_addr, sub_be;
   logic [63:0] sub_wdata, sub_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // captured subsystem requests
   int          rq_cnt = 0;
   logic [7:0]  rq_addr, rq_be;
   logic        rq_we;
   logic [63:0] rq_wdata;
   int          min_delay = 0;

   always #2 clk = ~clk;

   ind_reg_bridge #(.HOST_AW(8), .SUB_AW(8), .SYNC_STAGES(2), .ID_VALUE(IDV)) dut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .sub_req(sub_req), .sub_we(sub_we), .sub_addr(sub_addr), .sub_be(sub_be),
      .sub_wdata(sub_wdata), .sub_ack(sub_ack), .sub_rdata(sub_rdata),
      .sub_irq(sub_irq), .irq_out(irq_out)
   );

   function automatic logic [63:0] sub_model(input logic [7:0] a);
      logic [31:0] lo, hi;
      lo = 32'hC0DE_0000 | (32'(a) * 32'h0000_0101);
      hi = 32'h5EED_0000 ^ {a, 8'h3C, ~a, 8'h00};
      return {hi, lo};
   endfunction

   function automatic logic [7:0] exp_be(input logic sz, input logic [3:0] bu, input logic [3:0] bl);
      return {sz ? bu : 4'b0000, bl};
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_sel = 1'b0; host_we = 1'b0;
   endtask

   task automatic hread(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic peek_busy(output logic b, output logic r);
      host_addr = A_CTRL;
      #1 b = host_rdata[31];
      r = sub_req;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         host_addr = A_CTRL;
         #1;
         if (!host_rdata[31]) break;
      end
   endtask

   // subsystem responder
   initial begin
      sub_ack = 1'b0;
      sub_rdata = '0;
      forever begin
         @(negedge clk);
         sub_ack = 1'b0;
         if (sub_req === 1'b1) begin
            rq_addr = sub_addr; rq_we = sub_we; rq_be = sub_be; rq_wdata = sub_wdata;
            rq_cnt++;
            repeat (min_delay + int'($urandom_range(0, 3))) @(negedge clk);
            sub_rdata = sub_model(rq_addr);
            sub_ack = 1'b1;
            @(negedge clk);
            sub_ack = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd, cw, lo, hi, prev_hi;
      logic [7:0]  a;
      logic        sz, b, r;
      logic [3:0]  bu, bl;
      int          c0;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; host_sel = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0; sub_irq = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      hread(A_ID, rd);   chk("R1", "id", rd, IDV);
      hread(A_CTRL, rd); chk("R1", "ctrl", rd, 0);
      hread(A_DLO, rd);  chk("R1", "dlo", rd, 0);
      hread(A_DHI, rd);  chk("R1", "dhi", rd, 0);
      hread(A_IEN, rd);  chk("R1", "ien", rd, 0);
      hread(A_IFLG, rd); chk("R1", "iflg", rd, 0);
      chk("R1", "sub_req", sub_req, 0);
      chk("R1", "irq_out", irq_out, 0);

      // R11 unmapped and ID write
      hread(8'h18, rd); chk("R11", "unmapped 0x18", rd, 0);
      hread(8'hFC, rd); chk("R11", "unmapped 0xFC", rd, 0);
      hwrite(A_ID, 32'hFFFF_FFFF);
      hread(A_ID, rd); chk("R11", "id after write", rd, IDV);

      // R2 control layout, no launch with direction 0
      for (int i = 0; i < 6; i++) begin
         cw = $urandom & ~32'h0100_0000;
         c0 = rq_cnt;
         hwrite(A_CTRL, cw);
         repeat (3) @(negedge clk);
         hread(A_CTRL, rd); chk("R2", "ctrl readback", rd, cw & 32'h03FF_00FF);
         chk("R2", "no launch", rq_cnt, c0);
      end

      // R3 write transfers, R7 busy gating, R8/R9 completion flag
      for (int i = 0; i < 20; i++) begin
         a = 8'($urandom); sz = 1'($urandom); bu = 4'($urandom); bl = 4'($urandom);
         cw = {6'b0, sz, 1'b0, bu, bl, 8'h00, a};
         hwrite(A_CTRL, cw);
         hi = $urandom; hwrite(A_DHI, hi);
         lo = $urandom;
         min_delay = (i % 4 == 0) ? 12 : 0;
         c0 = rq_cnt;
         hwrite(A_DLO, lo);
         peek_busy(b, r);
         chk("R3", "busy after write launch", {b, r}, 2'b11);
         if (i % 4 == 0) begin
            hwrite(A_CTRL, ~cw);
            hwrite(A_DHI, ~hi);
            hwrite(A_DLO, ~lo);
         end
         wait_idle();
         repeat (2) @(negedge clk);
         chk("R7", "one request", rq_cnt, c0 + 1);
         chk("R3", "sub_we", rq_we, 1);
         chk("R3", "sub_addr", rq_addr, a);
         chk("R3", "sub_be", rq_be, exp_be(sz, bu, bl));
         chk("R3", "sub_wdata", rq_wdata, {hi, lo});
         chk("R5", "req low after ack", sub_req, 0);
         hread(A_CTRL, rd); chk("R7", "ctrl kept", rd, cw);
         hread(A_DLO, rd);  chk("R7", "dlo kept", rd, lo);
         hread(A_DHI, rd);  chk("R7", "dhi kept", rd, hi);
         hread(A_IFLG, rd); chk("R8", "done flag", rd, 1);
         hwrite(A_IFLG, 32'h0);
         hread(A_IFLG, rd); chk("R9", "write 0 keeps", rd, 1);
         hwrite(A_IFLG, 32'h1);
         hread(A_IFLG, rd); chk("R9", "w1c", rd, 0);
      end
      min_delay = 0;

      // R4 read transfers, R6 data return
      for (int i = 0; i < 20; i++) begin
         a = 8'($urandom); sz = (i % 2 == 0); bu = 4'($urandom); bl = 4'($urandom);
         cw = {6'b0, sz, 1'b1, bu, bl, 8'h00, a};
         hread(A_DHI, prev_hi);
         min_delay = int'($urandom_range(0, 5));
         c0 = rq_cnt;
         hwrite(A_CTRL, cw);
         peek_busy(b, r);
         chk("R4", "busy after read launch", {b, r}, 2'b11);
         wait_idle();
         repeat (2) @(negedge clk);
         chk("R4", "one request", rq_cnt, c0 + 1);
         chk("R4", "sub_we low", rq_we, 0);
         chk("R4", "sub_addr", rq_addr, a);
         chk("R4", "sub_be", rq_be, exp_be(sz, bu, bl));
         hread(A_DLO, rd); chk("R6", "dlo loaded", rd, sub_model(a)[31:0]);
         hread(A_DHI, rd); chk("R6", "dhi by size", rd, sz ? sub_model(a)[63:32] : prev_hi);
         hread(A_CTRL, rd); chk("R2", "ctrl idle readback", rd, cw);
         hwrite(A_IFLG, 32'h3);
      end
      min_delay = 0;

      // R8 / R10 interrupts
      hwrite(A_IEN, 32'h0);
      @(negedge clk); sub_irq = 1'b1;
      repeat (6) @(negedge clk);
      hread(A_IFLG, rd); chk("R8", "sub edge flag", rd, 2);
      chk("R10", "masked irq", irq_out, 0);
      hwrite(A_IEN, 32'hFFFF_FFFE);
      hread(A_IEN, rd); chk("R10", "ien readback", rd, 2);
      @(negedge clk); #1 chk("R10", "irq on sub", irq_out, 1);
      hwrite(A_IFLG, 32'h2);
      repeat (6) @(negedge clk);
      hread(A_IFLG, rd); chk("R8", "level does not reset flag", rd, 0);
      #1 chk("R10", "irq off after clear", irq_out, 0);
      sub_irq = 1'b0;
      repeat (4) @(negedge clk);
      sub_irq = 1'b1;
      repeat (6) @(negedge clk);
      hread(A_IFLG, rd); chk("R8", "second edge", rd, 2);
      hwrite(A_IEN, 32'h1);
      #1 chk("R10", "bit1 not enabled", irq_out, 0);
      hwrite(A_CTRL, 32'h0000_0042);
      hwrite(A_DLO, 32'h1234_5678);
      wait_idle();
      repeat (2) @(negedge clk);
      hread(A_IFLG, rd); chk("R8", "both flags", rd, 3);
      #1 chk("R10", "irq on done", irq_out, 1);
      hwrite(A_IFLG, 32'h1);
      hread(A_IFLG, rd); chk("R9", "only bit0 cleared", rd, 2);
      #1 chk("R10", "irq off", irq_out, 0);
      sub_irq = 1'b0;

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule